// File: doc/BRIEF.md
# External Bus Cycle Timing Sequencer

This block runs the timing of a single transfer on an external memory bus. The window has already been selected. A requester presents a start request together with a direction flag, a burst length and the 32-bit timing control word that belongs to the window. The sequencer then drives four strobes in order: an address-valid indication, a transfer-start strobe, a chip-select enable and a per-beat internal acknowledge. A done pulse marks the end of the transfer.

The control word sets several things. It sets how many edges pass between address and chip select. It sets how many wait states come before each beat is acknowledged, and a burst can use a separate count after its first beat. It sets whether beats end on an internal count or only on an external acknowledge. It sets how long address and attributes are held after the last beat. The word is captured when the request is accepted, so later changes to it cannot disturb a transfer already running.

The start interface is a valid/ready pair. `start_ready_o` is high only while the sequencer is idle. A request is taken on an edge where both `start_valid_i` and `start_ready_o` are high. A request raised while ready is low is not queued; it has no effect. The direction flag, burst length and control word are sampled only on the accepting edge.

Top module: `bus_cycle_seq`

## Requirements
- R1: After reset `start_ready_o` is 1, and `xfer_start_o`, `cs_o`, `addr_valid_o`, `ack_o` and `done_o` are 0.
- R2: If a start is accepted on edge E0, `addr_valid_o` rises after E0. `cs_o` rises after edge E(S+1), where S is the setup field in control bits 21:20 (0 to 3).
- R3: The first beat uses the primary wait field in bits 15:10 (0 to 63). With auto-acknowledge on, `ack_o` is high for one cycle, exactly W cycles after `cs_o` rises.
- R4: When the secondary enable bit 23 is 1, every beat after the first waits for the secondary count in bits 31:26. When bit 23 is 0, every beat uses the primary count.
- R5: With auto-acknowledge (bit 8) set, a beat ends on the internal count. If `ext_ack_i` is high on an edge before the count expires, the beat ends at that edge and no `ack_o` is produced for it.
- R6: With bit 8 clear, `ack_o` never rises. Each beat ends only on an edge where `ext_ack_i` is high.
- R7: After the last beat, `addr_valid_o` stays high with `cs_o` low for H cycles. For a write, H is the field in bits 17:16 plus 1. For a read, H is the field in bits 19:18 plus 1 when bit 8 is clear, and equals that field when bit 8 is set.
- R8: Within a burst, beats follow each other with `cs_o` held high and no hold cycles between them.
- R9: With bit 22 clear, `xfer_start_o` is high only in the cycle after the accepting edge. With bit 22 set, it stays high up to the first edge after `cs_o` rises.
- R10: `cs_o` falls on the edge after the final beat ends. `done_o` is a one-cycle pulse in the first idle cycle after the hold time.
- R11: The direction, burst length and control word are held from the accepting edge. A request or a change of these inputs while `start_ready_o` is low has no effect on the running transfer.
- R12: A transfer has `burst_len_m1_i + 1` beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_valid_i | input | 1 | Transfer request |
| start_ready_o | output | 1 | Sequencer idle, request can be taken |
| rd_i | input | 1 | 1 = read, 0 = write |
| burst_len_m1_i | input | BEAT_W | Number of beats minus one |
| ctrl_i | input | 32 | Timing control word of the selected window |
| ext_ack_i | input | 1 | External transfer acknowledge |
| xfer_start_o | output | 1 | Transfer-start strobe |
| cs_o | output | 1 | Chip-select enable |
| addr_valid_o | output | 1 | Address and attributes valid (setup through hold) |
| ack_o | output | 1 | Internal per-beat acknowledge |
| done_o | output | 1 | Transfer finished pulse |

## Verification
All outputs are decoded from registered state, so each one moves in the cycle after the edge that causes it. Number the accepting edge E0 and the cycle after edge Ek as cycle k. Then address-valid is due in cycle 0, chip select in cycle S+1, and the first acknowledge in cycle S+1+W. Each later beat ends its own wait length after the previous one, the hold covers cycles L+1 to L+H, and done falls in cycle L+H+1, where L is the last beat cycle. The bench works these cycle numbers out from the field values alone and compares every output in every cycle at the falling clock edge. It drives the external acknowledge during the chosen beat cycle so that the edge which ends the cycle samples it.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

  localparam int WAIT_W  = 6;
  localparam int SETUP_W = 2;
  localparam int HOLD_W  = 2;
  localparam int CTRL_W  = 32;

  // Timing control word; bit positions are fixed by software programming.
  typedef struct packed {
    logic [WAIT_W-1:0]  sec_wait;   // 31:26
    logic [1:0]         spare_hi;   // 25:24
    logic               sec_en;     // 23
    logic               ext_start;  // 22
    logic [SETUP_W-1:0] setup;      // 21:20
    logic [HOLD_W-1:0]  rd_hold;    // 19:18
    logic [HOLD_W-1:0]  wr_hold;    // 17:16
    logic [WAIT_W-1:0]  pri_wait;   // 15:10
    logic               spare_9;    // 9
    logic               auto_ack;   // 8
    logic [7:0]         spare_lo;   // 7:0
  } ctrl_word_t;

  // Fields the sequencer needs after the setup phase.
  typedef struct packed {
    logic [WAIT_W-1:0] sec_wait;
    logic              sec_en;
    logic              ext_start;
    logic              auto_ack;
    logic [WAIT_W-1:0] pri_wait;
  } tcfg_t;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_WAIT  = 3'd2,
    ST_ACK   = 3'd3,
    ST_HOLD  = 3'd4
  } seq_state_e;

endpackage

// File: rtl/bcs_ctrl_latch.sv
module bcs_ctrl_latch
  import bcs_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                capture_i,
  input  ctrl_word_t          word_i,
  input  logic                rd_i,
  output tcfg_t               cfg_o,
  output logic [HOLD_W:0]     hold_o
);

  tcfg_t             cfg_q;
  logic              rd_q;
  logic [HOLD_W-1:0] rd_hold_q;
  logic [HOLD_W-1:0] wr_hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q     <= '0;
      rd_q      <= 1'b0;
      rd_hold_q <= '0;
      wr_hold_q <= '0;
    end else if (capture_i) begin
      cfg_q.sec_wait  <= word_i.sec_wait;
      cfg_q.sec_en    <= word_i.sec_en;
      cfg_q.ext_start <= word_i.ext_start;
      cfg_q.auto_ack  <= word_i.auto_ack;
      cfg_q.pri_wait  <= word_i.pri_wait;
      rd_q            <= rd_i;
      rd_hold_q       <= word_i.rd_hold;
      wr_hold_q       <= word_i.wr_hold;
    end
  end

  // Hold length in cycles; a read with internal acknowledge saves one cycle.
  logic [HOLD_W:0] rd_len;
  logic [HOLD_W:0] wr_len;

  always_comb begin
    rd_len = {1'b0, rd_hold_q};
    if (!cfg_q.auto_ack) rd_len = rd_len + 1'b1;
    wr_len = {1'b0, wr_hold_q} + 1'b1;
  end

  assign cfg_o  = cfg_q;
  assign hold_o = rd_q ? rd_len : wr_len;

endmodule

// File: rtl/bcs_down_counter.sv
module bcs_down_counter #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic [W-1:0] count_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign count_o = cnt_q;

endmodule

// File: rtl/bcs_seq_fsm.sv
module bcs_seq_fsm
  import bcs_pkg::*;
#(
  parameter int BEAT_W = 4,
  parameter int CNT_W  = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_valid_i,
  input  logic [BEAT_W-1:0]  burst_len_m1_i,
  input  logic [SETUP_W-1:0] setup_i,
  input  tcfg_t              cfg_i,
  input  logic [HOLD_W:0]    hold_i,
  input  logic               ext_ack_i,
  input  logic [CNT_W-1:0]   count_i,
  output seq_state_e         state_o,
  output logic               cnt_load_o,
  output logic [CNT_W-1:0]   cnt_val_o,
  output logic               capture_o,
  output logic               xfer_start_o,
  output logic               done_o
);

  seq_state_e        state_q, state_d;
  logic [BEAT_W-1:0] beats_q, beats_d;
  logic              done_q, done_d;
  logic              ts_q;
  logic              accept;
  logic              beat_end;
  logic [CNT_W-1:0]  first_wait;
  logic [CNT_W-1:0]  later_wait;
  logic [CNT_W-1:0]  hold_val;

  assign accept     = start_valid_i && (state_q == ST_IDLE);
  assign first_wait = CNT_W'(cfg_i.pri_wait);
  assign later_wait = cfg_i.sec_en ? CNT_W'(cfg_i.sec_wait) : first_wait;
  assign hold_val   = CNT_W'(hold_i) - 1'b1;

  always_comb begin
    state_d    = state_q;
    beats_d    = beats_q;
    done_d     = 1'b0;
    cnt_load_o = 1'b0;
    cnt_val_o  = '0;
    beat_end   = 1'b0;

    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          state_d    = ST_SETUP;
          cnt_load_o = 1'b1;
          cnt_val_o  = CNT_W'(setup_i);
          beats_d    = burst_len_m1_i;
        end
      end
      ST_SETUP: begin
        if (count_i == '0) begin
          cnt_load_o = 1'b1;
          cnt_val_o  = first_wait;
          state_d    = (cfg_i.auto_ack && first_wait == '0) ? ST_ACK : ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (ext_ack_i)
          beat_end = 1'b1;
        else if (cfg_i.auto_ack && count_i == CNT_W'(1))
          state_d = ST_ACK;
      end
      ST_ACK: beat_end = 1'b1;
      ST_HOLD: begin
        if (count_i == '0) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase

    if (beat_end) begin
      if (beats_q == '0) begin
        if (hold_i == '0) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end else begin
          state_d    = ST_HOLD;
          cnt_load_o = 1'b1;
          cnt_val_o  = hold_val;
        end
      end else begin
        beats_d    = beats_q - 1'b1;
        cnt_load_o = 1'b1;
        cnt_val_o  = later_wait;
        state_d    = (cfg_i.auto_ack && later_wait == '0) ? ST_ACK : ST_WAIT;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      beats_q <= '0;
      done_q  <= 1'b0;
      ts_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      beats_q <= beats_d;
      done_q  <= done_d;
      if (accept)
        ts_q <= 1'b1;
      else if (state_q != ST_SETUP || !cfg_i.ext_start)
        ts_q <= 1'b0;
    end
  end

  assign state_o      = state_q;
  assign capture_o    = accept;
  assign xfer_start_o = ts_q;
  assign done_o       = done_q;

endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
  import bcs_pkg::*;
#(
  parameter int BEAT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_valid_i,
  output logic              start_ready_o,
  input  logic              rd_i,
  input  logic [BEAT_W-1:0] burst_len_m1_i,
  input  logic [31:0]       ctrl_i,
  input  logic              ext_ack_i,
  output logic              xfer_start_o,
  output logic              cs_o,
  output logic              addr_valid_o,
  output logic              ack_o,
  output logic              done_o
);

  localparam int CNT_W = (WAIT_W > HOLD_W + 1) ? WAIT_W : HOLD_W + 1;

  ctrl_word_t       word;
  tcfg_t            cfg;
  logic [HOLD_W:0]  hold_len;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] cnt_val;
  logic             cnt_load;
  logic             capture;
  seq_state_e       state;
  logic             unused_spare;

  assign word         = ctrl_word_t'(ctrl_i);
  assign unused_spare = ^{word.spare_hi, word.spare_9, word.spare_lo};

  bcs_ctrl_latch u_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture_i (capture),
    .word_i    (word),
    .rd_i      (rd_i),
    .cfg_o     (cfg),
    .hold_o    (hold_len)
  );

  bcs_down_counter #(.W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (cnt_load),
    .load_val_i (cnt_val),
    .count_o    (count)
  );

  bcs_seq_fsm #(.BEAT_W(BEAT_W), .CNT_W(CNT_W)) u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_valid_i  (start_valid_i),
    .burst_len_m1_i (burst_len_m1_i),
    .setup_i        (word.setup),
    .cfg_i          (cfg),
    .hold_i         (hold_len),
    .ext_ack_i      (ext_ack_i),
    .count_i        (count),
    .state_o        (state),
    .cnt_load_o     (cnt_load),
    .cnt_val_o      (cnt_val),
    .capture_o      (capture),
    .xfer_start_o   (xfer_start_o),
    .done_o         (done_o)
  );

  assign start_ready_o = (state == ST_IDLE);
  assign addr_valid_o  = (state != ST_IDLE);
  assign cs_o          = (state == ST_WAIT) || (state == ST_ACK);
  assign ack_o         = (state == ST_ACK);

endmodule

// File: rtl/bus_cycle_seq_checker.sv
module bus_cycle_seq_checker (
  input logic clk,
  input logic rst_n,
  input logic start_valid_i,
  input logic start_ready_o,
  input logic ext_ack_i,
  input logic xfer_start_o,
  input logic cs_o,
  input logic addr_valid_o,
  input logic ack_o,
  input logic done_o
);

  assert_cs_inside_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_o |-> (addr_valid_o && !start_ready_o));

  assert_ack_inside_cs_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> cs_o);

  assert_start_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(addr_valid_o) |-> xfer_start_o);

  assert_cs_drop_after_beat_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_o) |-> ($past(ack_o) || $past(ext_ack_i)));

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_when_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (start_ready_o && !addr_valid_o));

  assert_accept_begins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (start_valid_i && start_ready_o) |=> (addr_valid_o && xfer_start_o && !start_ready_o));

endmodule

bind bus_cycle_seq bus_cycle_seq_checker u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .start_valid_i (start_valid_i),
  .start_ready_o (start_ready_o),
  .ext_ack_i     (ext_ack_i),
  .xfer_start_o  (xfer_start_o),
  .cs_o          (cs_o),
  .addr_valid_o  (addr_valid_o),
  .ack_o         (ack_o),
  .done_o        (done_o)
);

// File: tb/bus_cycle_seq_test.sv
module bus_cycle_seq_test;

  localparam int CLK_PERIOD = 10;
  localparam int BEAT_W     = 4;
  localparam int WATCHDOG   = 150000;

  logic              clk;
  logic              rst_n;
  logic              start_valid_i;
  logic              start_ready_o;
  logic              rd_i;
  logic [BEAT_W-1:0] burst_len_m1_i;
  logic [31:0]       ctrl_i;
  logic              ext_ack_i;
  logic              xfer_start_o;
  logic              cs_o;
  logic              addr_valid_o;
  logic              ack_o;
  logic              done_o;

  int errors = 0;
  int checks = 0;

  bus_cycle_seq #(.BEAT_W(BEAT_W)) uut (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_valid_i  (start_valid_i),
    .start_ready_o  (start_ready_o),
    .rd_i           (rd_i),
    .burst_len_m1_i (burst_len_m1_i),
    .ctrl_i         (ctrl_i),
    .ext_ack_i      (ext_ack_i),
    .xfer_start_o   (xfer_start_o),
    .cs_o           (cs_o),
    .addr_valid_o   (addr_valid_o),
    .ack_o          (ack_o),
    .done_o         (done_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s at %0t: actual=%0b expected=%0b", tag, what, $time, act, exp);
    end
  endtask

  // One transfer; every output compared in every cycle against arithmetic expectations.
  task automatic run_xfer(input int aset, input int ws, input int sws, input int swsen,
                          input int aa, input int rd, input int wh, input int rh,
                          input int exts, input int nb, input int ext_pos);
    int e_cyc[16];
    int x_cyc[16];
    bit auto_b[16];
    int cur, wb, len, last, h, cs0;
    bit used;
    logic [31:0] w;
    string ack_tag, cs_tag, done_tag;

    cs0 = aset + 1;
    cur = cs0;
    for (int b = 0; b < nb; b++) begin
      wb        = (b > 0 && swsen != 0) ? sws : ws;
      used      = (ext_pos >= 0) && (aa == 0 || ext_pos <= wb);
      len       = used ? ext_pos + 1 : wb + 1;
      auto_b[b] = (aa != 0) && !(used && ext_pos < wb);
      x_cyc[b]  = used ? cur + ext_pos : -1;
      e_cyc[b]  = cur + len - 1;
      cur       = e_cyc[b] + 1;
    end
    last = e_cyc[nb-1];
    h    = (rd != 0) ? ((aa != 0) ? rh : rh + 1) : wh + 1;

    w = (sws << 26) | (swsen << 23) | (exts << 22) | (aset << 20) |
        (rh << 18) | (wh << 16) | (ws << 10) | (aa << 8);

    ack_tag  = (aa == 0) ? "R6" : ((ext_pos >= 0) ? "R5" : ((swsen != 0 && nb > 1) ? "R4" : "R3"));
    cs_tag   = (nb > 1) ? "R8" : "R2";
    done_tag = (nb > 1) ? "R12" : "R10";

    start_valid_i  = 1'b1;
    rd_i           = rd[0];
    burst_len_m1_i = BEAT_W'(nb - 1);
    ctrl_i         = w;
    ext_ack_i      = 1'b0;
    @(posedge clk);
    for (int k = 0; k <= last + h + 2; k++) begin
      bit exp_ack;
      @(negedge clk);
      exp_ack = 1'b0;
      for (int b = 0; b < nb; b++)
        if (auto_b[b] && e_cyc[b] == k) exp_ack = 1'b1;
      chk("R11", "start_ready_o", start_ready_o, k >= last + h + 1);
      chk("R7",  "addr_valid_o",  addr_valid_o,  k <= last + h);
      chk("R9",  "xfer_start_o",  xfer_start_o,  (exts != 0) ? (k <= aset + 1) : (k == 0));
      chk(cs_tag, "cs_o",         cs_o,          k >= cs0 && k <= last);
      chk(ack_tag, "ack_o",       ack_o,         exp_ack);
      chk(done_tag, "done_o",     done_o,        k == last + h + 1);
      // R11: a second request and altered inputs while busy must change nothing.
      if (k == 0) begin
        start_valid_i  = 1'b1;
        ctrl_i         = ~w;
        rd_i           = ~rd[0];
        burst_len_m1_i = ~BEAT_W'(nb - 1);
      end else begin
        start_valid_i = 1'b0;
      end
      ext_ack_i = 1'b0;
      for (int b = 0; b < nb; b++)
        if (x_cyc[b] == k) ext_ack_i = 1'b1;
    end
    ext_ack_i     = 1'b0;
    start_valid_i = 1'b0;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R10 watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int ws_t[4]  = '{0, 2, 3, 1};
    int sws_t[4] = '{0, 5, 1, 0};
    int sen_t[4] = '{0, 1, 0, 1};
    int nb_t[4]  = '{1, 3, 2, 4};
    int ext_t[4] = '{-1, -1, 1, 0};

    rst_n          = 1'b0;
    start_valid_i  = 1'b0;
    rd_i           = 1'b0;
    burst_len_m1_i = '0;
    ctrl_i         = '0;
    ext_ack_i      = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "start_ready_o", start_ready_o, 1'b1);
    chk("R1", "xfer_start_o",  xfer_start_o,  1'b0);
    chk("R1", "cs_o",          cs_o,          1'b0);
    chk("R1", "addr_valid_o",  addr_valid_o,  1'b0);
    chk("R1", "ack_o",         ack_o,         1'b0);
    chk("R1", "done_o",        done_o,        1'b0);

    for (int aset = 0; aset < 4; aset++)
      for (int exts = 0; exts < 2; exts++)
        for (int aa = 0; aa < 2; aa++)
          for (int rd = 0; rd < 2; rd++)
            for (int hf = 0; hf < 4; hf++)
              for (int c = 0; c < 4; c++) begin
                int ep;
                ep = (aa == 0 && ext_t[c] < 0) ? 2 : ext_t[c];
                run_xfer(aset, ws_t[c], sws_t[c], sen_t[c], aa, rd, hf, 3 - hf, exts, nb_t[c], ep);
              end

    // Wait-count extremes and the external acknowledge landing on the expiry cycle.
    run_xfer(0, 63, 0, 0, 1, 1, 0, 1, 0, 1, -1);
    run_xfer(1, 0, 63, 1, 1, 0, 2, 0, 1, 2, -1);
    run_xfer(2, 5, 0, 0, 1, 0, 1, 1, 0, 1, 5);
    run_xfer(0, 63, 63, 1, 0, 1, 0, 3, 0, 3, 1);
    run_xfer(3, 4, 2, 1, 1, 1, 3, 0, 1, 16, -1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule